// File: doc/BRIEF.md
# Dual-Port Synthesizer Configuration Loader

This block holds the divider settings of a clock synthesizer: a loop divide value, an output divide code and a test-select code. Software or board logic can set them in two ways. The first is a bank of parallel pins with a load strobe. The second is a three-wire serial port made of data, shift clock and load strobe. Both ports write into one shared set of configuration holding registers. The parallel port wins whenever the two ports conflict.

All port inputs are asynchronous to the system clock. Each input passes through a synchronizer. A shift register advances on each synchronized rising edge of the serial shift clock. A small state machine then decides every cycle which source the holding registers follow. It has three states. LD_PAR tracks the parallel pins while the parallel strobe is low. LD_SER tracks the shift register while the serial strobe is high and the parallel strobe is high. LD_HOLD keeps the captured value.

The next state depends only on the current strobe levels. Any state can go to LD_PAR when the parallel strobe is low. Any state can go to LD_SER when the parallel strobe is high and the serial strobe is high. Any state can go to LD_HOLD when the parallel strobe is high and the serial strobe is low. A capture therefore happens when the state leaves a tracking state for LD_HOLD: on the rising edge of the parallel strobe, or on the falling edge of the serial strobe. The oldest bit of the shift register is brought out on its own pin.

Top module: `synth_cfg_loader`

## Requirements
- R1: While the asynchronous reset is held, `cfg_m` equals parameter M_RST, `cfg_n` equals N_RST, `cfg_t` is 000 and `sr_last` is 0. With the parallel strobe high and the serial strobe low after reset, these values are kept.
- R2: The 14-bit shift register moves by one place on each rising edge of `ser_clk` and takes in `ser_data`. `sr_last` shows the bit that was shifted in 14 edges earlier.
- R3: The serial word is sent in this order: the three test bits first, then the two output-divide bits, then the nine loop-divide bits. Each field is sent most significant bit first. After 14 shifts, bits 13..11 of the register form T, bits 10..9 form N and bits 8..0 form M.
- R4: While `par_load` is high and `ser_load` is high, the three fields follow the shift register. On the falling edge of `ser_load` they keep the value they last had.
- R5: While `par_load` is low, `cfg_m` and `cfg_n` follow `par_m` and `par_n`. On the rising edge of `par_load` they keep the value they last had.
- R6: While `par_load` is low, `cfg_t` is 000. `cfg_t` stays 000 after the parallel capture, so the parallel pins cannot set it.
- R7: When both strobes are active together (`par_load` low and `ser_load` high), the parallel pins drive the fields and `cfg_t` is 000.
- R8: While `par_load` is high and `ser_load` is low, the fields do not change. This holds even when serial shifting goes on or the parallel pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_load | input | 1 | Parallel strobe: the fields track the pins while it is low and capture on its rise |
| par_m | input | 9 | Parallel loop-divide value |
| par_n | input | 2 | Parallel output-divide code (00 gives /2, 01 gives /4, 10 gives /8, 11 gives /16) |
| ser_clk | input | 1 | Serial shift clock, sampled for rising edges |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial strobe: the fields track the shift register while it is high and capture on its fall |
| cfg_m | output | 9 | Held loop-divide value |
| cfg_n | output | 2 | Held output-divide code |
| cfg_t | output | 3 | Held test-select code |
| sr_last | output | 1 | Oldest stage of the shift register |

## Verification
The bench builds the block with M_RST = 200, N_RST = 01 and SYNC_STAGES = 3. With these values the reset value can be told apart from any value loaded afterwards. The deeper synchronizer also stretches the delay from a strobe to the change in the fields. This lets the bench show that captures follow the strobe edges and not their raw timing. The overlap of both strobes, transparent serial tracking and hold during shifting are all reached with slow serial clocks driven against the fast system clock.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    typedef enum logic [1:0] {
        LD_HOLD = 2'd0,
        LD_PAR  = 2'd1,
        LD_SER  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int LEN = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_lvl,
    input  logic           sdat_lvl,
    output logic [LEN-1:0] sr,
    output logic           shift_pulse
);

    logic sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_lvl;
    end

    assign shift_pulse = sclk_lvl & ~sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           sr <= '0;
        else if (shift_pulse) sr <= {sr[LEN-2:0], sdat_lvl};
    end

endmodule

// File: rtl/cfg_latch_fsm.sv
module cfg_latch_fsm
    import cfg_ldr_pkg::*;
#(
    parameter int              M_W   = 9,
    parameter int              N_W   = 2,
    parameter int              T_W   = 3,
    parameter logic [M_W-1:0]  M_RST = '0,
    parameter logic [N_W-1:0]  N_RST = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_lvl,
    input  logic           ser_lvl,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic [M_W-1:0] sr_m,
    input  logic [N_W-1:0] sr_n,
    input  logic [T_W-1:0] sr_t,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t
);

    ld_state_e state, state_nx;

    // parallel strobe low beats everything; serial strobe only counts otherwise
    always_comb begin
        unique case ({par_lvl, ser_lvl})
            2'b00, 2'b01: state_nx = LD_PAR;
            2'b11:        state_nx = LD_SER;
            default:      state_nx = LD_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_HOLD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_m <= M_RST;
            cfg_n <= N_RST;
            cfg_t <= '0;
        end else begin
            unique case (state)
                LD_PAR: begin
                    cfg_m <= par_m;
                    cfg_n <= par_n;
                    cfg_t <= '0;
                end
                LD_SER: begin
                    cfg_m <= sr_m;
                    cfg_n <= sr_n;
                    cfg_t <= sr_t;
                end
                default: begin
                    cfg_m <= cfg_m;
                    cfg_n <= cfg_n;
                    cfg_t <= cfg_t;
                end
            endcase
        end
    end

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
    parameter int              M_W         = 9,
    parameter int              N_W         = 2,
    parameter int              T_W         = 3,
    parameter int              SYNC_STAGES = 2,
    parameter logic [M_W-1:0]  M_RST       = 9'd256,
    parameter logic [N_W-1:0]  N_RST       = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t,
    output logic           sr_last
);

    localparam int SR_W = T_W + N_W + M_W;
    localparam int PB_W = M_W + N_W;

    logic            par_lvl, ser_lvl, sclk_lvl, sdat_lvl, shift_pulse;
    logic [PB_W-1:0] par_bus_s;
    logic [M_W-1:0]  par_m_s;
    logic [N_W-1:0]  par_n_s;
    logic [SR_W-1:0] sr;

    // parallel strobe idles high so reset does not start a parallel load
    cfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pl (
        .clk(clk), .rst_n(rst_n), .d(par_load), .q(par_lvl));

    cfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sl (
        .clk(clk), .rst_n(rst_n), .d(ser_load), .q(ser_lvl));

    cfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_sp (
        .clk(clk), .rst_n(rst_n), .d({ser_clk, ser_data}), .q({sclk_lvl, sdat_lvl}));

    cfg_sync #(.W(PB_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pb (
        .clk(clk), .rst_n(rst_n), .d({par_m, par_n}), .q(par_bus_s));

    assign par_m_s = par_bus_s[PB_W-1:N_W];
    assign par_n_s = par_bus_s[N_W-1:0];

    ser_shift #(.LEN(SR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl), .sdat_lvl(sdat_lvl),
        .sr(sr), .shift_pulse(shift_pulse));

    assign sr_last = sr[SR_W-1];

    cfg_latch_fsm #(
        .M_W(M_W), .N_W(N_W), .T_W(T_W), .M_RST(M_RST), .N_RST(N_RST)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .par_lvl(par_lvl), .ser_lvl(ser_lvl),
        .par_m(par_m_s), .par_n(par_n_s),
        .sr_m(sr[M_W-1:0]), .sr_n(sr[M_W+N_W-1:M_W]), .sr_t(sr[SR_W-1:M_W+N_W]),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t));

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   par_lvl,
    input logic                   ser_lvl,
    input logic                   shift_pulse,
    input logic [T_W+N_W+M_W-1:0] sr,
    input logic [M_W-1:0]         par_m_s,
    input logic [N_W-1:0]         par_n_s,
    input logic [M_W-1:0]         cfg_m,
    input logic [N_W-1:0]         cfg_n,
    input logic [T_W-1:0]         cfg_t
);

    localparam int SR_W = T_W + N_W + M_W;

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> (sr[SR_W-1:1] == $past(sr[SR_W-2:0])));

    // R2
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(sr));

    // R6
    t_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(par_lvl) |=> (cfg_t == '0));

    // R5
    par_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(par_lvl) |=> (cfg_m == $past(par_m_s) && cfg_n == $past(par_n_s)));

    // R4
    ser_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(par_lvl) && $past(ser_lvl)) |=> (cfg_m == $past(sr[M_W-1:0])
            && cfg_t == $past(sr[SR_W-1:SR_W-T_W])));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(par_lvl) && !$past(ser_lvl)) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));

endmodule

bind synth_cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .par_lvl(par_lvl), .ser_lvl(ser_lvl),
    .shift_pulse(shift_pulse), .sr(sr), .par_m_s(par_m_s), .par_n_s(par_n_s),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t));

// File: tb/synth_cfg_loader_test.sv
`timescale 1ns/1ps
module synth_cfg_loader_test;

    localparam logic [8:0] M_DEF = 9'd200;
    localparam logic [1:0] N_DEF = 2'b01;
    localparam int         PH    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load = 1'b1;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [8:0] cfg_m;
    logic [1:0] cfg_n;
    logic [2:0] cfg_t;
    logic       sr_last;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;

    logic [13:0] exp_sr = '0;
    logic [8:0]  exp_m;
    logic [1:0]  exp_n;
    logic [2:0]  exp_t;

    always #2 clk = ~clk;

    synth_cfg_loader #(.SYNC_STAGES(3), .M_RST(M_DEF), .N_RST(N_DEF)) uut (
        .clk(clk), .rst_n(rst_n), .par_load(par_load), .par_m(par_m), .par_n(par_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .sr_last(sr_last));

    function automatic logic [2:0] word_t(input logic [13:0] w); return w[13:11]; endfunction
    function automatic logic [1:0] word_n(input logic [13:0] w); return w[10:9];  endfunction
    function automatic logic [8:0] word_m(input logic [13:0] w); return w[8:0];   endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_fields(input string tag);
        chk({tag, " m"}, 32'(cfg_m), 32'(exp_m));
        chk({tag, " n"}, 32'(cfg_n), 32'(exp_n));
        chk({tag, " t"}, 32'(cfg_t), 32'(exp_t));
    endtask

    // shift one word, MSB first; checks sr_last after every bit (R2)
    task automatic shift_word(input logic [13:0] w, input bit track);
        for (int i = 13; i >= 0; i--) begin
            ser_data = w[i];
            wait_cyc(PH);
            ser_clk = 1'b1;
            wait_cyc(PH);
            ser_clk = 1'b0;
            exp_sr = {exp_sr[12:0], w[i]};
            wait_cyc(PH);
            chk("R2 sr_last", 32'(sr_last), 32'(exp_sr[13]));
            if (track) begin
                exp_m = word_m(exp_sr); exp_n = word_n(exp_sr); exp_t = word_t(exp_sr);
            end
        end
    endtask

    task automatic ser_pulse();
        ser_load = 1'b1;
        wait_cyc(PH);
        exp_m = word_m(exp_sr); exp_n = word_n(exp_sr); exp_t = word_t(exp_sr);
        ser_load = 1'b0;
        wait_cyc(PH);
    endtask

    initial begin
        logic [13:0] w;
        void'($urandom(32'd4242));
        wait_cyc(3);
        exp_m = M_DEF; exp_n = N_DEF; exp_t = 3'b000;
        chk_fields("R1 in reset");
        chk("R1 sr_last", 32'(sr_last), 32'd0);
        rst_n = 1'b1;
        wait_cyc(12);
        chk_fields("R1 after reset");

        // R3: directed word with distinct fields, then serial load
        w = {3'b101, 2'b10, 9'h1A5};
        shift_word(w, 0);
        chk_fields("R8 shift without load");
        ser_pulse();
        chk_fields("R3 field order");

        // R4: transparent while ser_load high, held after fall
        ser_load = 1'b1;
        wait_cyc(PH);
        w = {3'b011, 2'b01, 9'h0F3};
        shift_word(w, 1);
        chk_fields("R4 tracking");
        ser_load = 1'b0;
        wait_cyc(PH);
        shift_word(14'h2AAA, 0);
        chk_fields("R4 held after fall");

        // R5/R6: parallel tracking, forced T, capture on rise
        par_m = 9'd333; par_n = 2'b11; par_load = 1'b0;
        wait_cyc(PH);
        exp_m = 9'd333; exp_n = 2'b11; exp_t = 3'b000;
        chk_fields("R5 R6 tracking");
        par_m = 9'd250; par_n = 2'b00;
        wait_cyc(PH);
        exp_m = 9'd250; exp_n = 2'b00;
        chk_fields("R5 follows change");
        par_load = 1'b1;
        wait_cyc(PH);
        par_m = 9'd401; par_n = 2'b10;
        wait_cyc(PH);
        chk_fields("R5 held after rise");
        chk("R6 t after capture", 32'(cfg_t), 32'd0);

        // R7: both strobes active
        ser_load = 1'b1;
        wait_cyc(PH);
        par_load = 1'b0;
        wait_cyc(PH);
        exp_m = 9'd401; exp_n = 2'b10; exp_t = 3'b000;
        chk_fields("R7 overlap");
        ser_load = 1'b0;
        wait_cyc(PH);
        par_load = 1'b1;
        wait_cyc(PH);
        chk_fields("R7 after release");

        // random mix
        for (int k = 0; k < 20; k++) begin
            if ($urandom % 2) begin
                w = 14'($urandom);
                shift_word(w, 0);
                ser_pulse();
                chk_fields("R3 R4 random serial");
            end else begin
                par_m = 9'($urandom); par_n = 2'($urandom);
                par_load = 1'b0;
                wait_cyc(PH);
                exp_m = par_m; exp_n = par_n; exp_t = 3'b000;
                chk("R6 random t", 32'(cfg_t), 32'd0);
                par_load = 1'b1;
                wait_cyc(PH);
                par_m = 9'($urandom); par_n = 2'($urandom);
                wait_cyc(PH);
                chk_fields("R5 R8 random parallel");
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule